// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that a processor drives through four memory-mapped 32-bit registers. It generates the management clock (MDC) and drives a shared bidirectional data line as separate output, output-enable and input signals. It can build both the short-address frame format (Clause 22) and the extended-address frame format (Clause 45). One status bit selects which format is used.

Register writes start transactions. In extended mode, a write to the address word sends an address frame. A write to the data word sends a write frame. A write to the control word with its read bit set sends a read frame. A busy flag covers the whole frame. The sampled register value lands in the data word when a read finishes. A read-error flag records whether the addressed device failed to take the line during turnaround.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read 0, MDC is low and the output-enable is low.
- R2: The word address selects the register: 12 = status, 13 = control, 14 = data, 15 = address; words 0..11 read 0. Status bits 15:8 hold the divider and bit 6 the format select (1 = Clause 45); control bits 4:0 hold the device/register address, bits 9:5 the port address and bit 10 the preamble disable; address bits 15:0 hold the extended register address; all read back as written.
- R3: MDC idles low and each frame bit takes one MDC period (low half, then high half). Each half lasts max(divider,1) system clocks, so a frame of N bits keeps busy high for N*2*max(divider,1) clocks.
- R4: Each frame starts with 32 one bits unless control bit 10 is set, in which case no preamble is sent.
- R5: A Clause 22 frame carries start 01, opcode 01 (write) or 10 (read), then the 5-bit port address, the 5-bit control address field, a turnaround and 16 data bits, most significant bit first. On writes, the turnaround is driven as 10.
- R6: A Clause 45 frame carries start 00 and opcode 00 (address), 01 (write) or 11 (read), in the same layout. In Clause 22 mode, an address-word write only stores the value and starts no frame.
- R7: On a read, the master releases the line after the first 14 frame bits. It samples the 16 data bits on MDC rising edges and loads them into data bits 15:0 when the frame ends.
- R8: On a read, status bit 1 is set when the second turnaround bit is sampled high; otherwise it is left clear.
- R9: Status bit 0 and data bit 31 read 1 from the clock after a starting write until the frame ends. Busy and read-error are cleared when a frame starts.
- R10: Any register write while busy is ignored: stored fields do not change and no new frame starts.
- R11: The output-enable is high only while busy. The data output changes only on MDC falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
On every cycle, the assertions check the line discipline. MDC stays low and the output-enable stays off when idle. The output bit moves only on MDC falls. Read-error is clear when a frame begins, and it can only rise during a frame. Frame content, preamble suppression, the exact busy length for a given divider, the captured read value and the ignoring of writes while busy can only be shown by the bench scenarios. These scenarios use a bit-level device model that records the master's bits on MDC rises and answers reads after MDC falls.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TOTAL = PRE_LEN + 32;
  localparam int IDX_W = $clog2(TOTAL + 1);
  localparam logic [3:0] A_STAT = 4'd12, A_CTRL = 4'd13, A_DATA = 4'd14, A_ADDR = 4'd15;
  localparam logic [IDX_W-1:0] I_PRE  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(TOTAL - 1);

  logic             c45_q, pdis_q, busy_q, rd_err_q, mdc_q, rd_q;
  logic [7:0]       div_q, hcnt_q;
  logic [4:0]       dev_q, port_q;
  logic [15:0]      data_q, addr_q, rx_q;
  logic [31:0]      sr_q;
  logic [IDX_W-1:0] idx_q;

  logic unused_hi;
  assign unused_hi = ^bus_wdata[31:16];

  wire wr_ok   = bus_wr && !busy_q;
  wire go_addr = wr_ok && bus_addr == A_ADDR && c45_q;
  wire go_wr   = wr_ok && bus_addr == A_DATA;
  wire go_rd   = wr_ok && bus_addr == A_CTRL && bus_wdata[15];
  wire go      = go_addr || go_wr || go_rd;

  wire [7:0]  half_m1 = (div_q == 8'd0) ? 8'd0 : div_q - 8'd1;
  wire [1:0]  f_st    = c45_q ? 2'b00 : 2'b01;
  wire [1:0]  f_op    = go_addr ? 2'b00 : go_wr ? 2'b01 : (c45_q ? 2'b11 : 2'b10);
  wire [4:0]  f_port  = go_rd ? bus_wdata[9:5] : port_q;
  wire [4:0]  f_dev   = go_rd ? bus_wdata[4:0] : dev_q;
  wire        f_pdis  = go_rd ? bus_wdata[10] : pdis_q;
  wire [15:0] f_data  = go_rd ? 16'hFFFF : bus_wdata[15:0];

  wire [IDX_W-1:0] pos      = idx_q - I_PRE;
  wire             in_frame = idx_q >= I_PRE;
  wire             released = rd_q && in_frame && pos >= IDX_W'(14);

  assign mdc     = mdc_q;
  assign mdio_oe = busy_q && !released;
  assign mdio_o  = busy_q && in_frame ? sr_q[31] : 1'b1;

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {16'h0, div_q, 1'b0, c45_q, 4'h0, rd_err_q, busy_q};
      A_CTRL:  bus_rdata = {21'h0, pdis_q, port_q, dev_q};
      A_DATA:  bus_rdata = {busy_q, 15'h0, data_q};
      A_ADDR:  bus_rdata = {16'h0, addr_q};
      default: bus_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c45_q <= 1'b0; pdis_q <= 1'b0; div_q <= 8'h0;
      dev_q <= 5'h0; port_q <= 5'h0;
      data_q <= 16'h0; addr_q <= 16'h0;
    end else begin
      if (wr_ok) begin
        case (bus_addr)
          A_STAT: begin c45_q <= bus_wdata[6]; div_q <= bus_wdata[15:8]; end
          A_CTRL: begin dev_q <= bus_wdata[4:0]; port_q <= bus_wdata[9:5]; pdis_q <= bus_wdata[10]; end
          A_DATA: data_q <= bus_wdata[15:0];
          A_ADDR: addr_q <= bus_wdata[15:0];
          default: ;
        endcase
      end
      if (busy_q && hcnt_q == 8'd0 && mdc_q && idx_q == I_LAST && rd_q)
        data_q <= rx_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rd_err_q <= 1'b0; mdc_q <= 1'b0; rd_q <= 1'b0;
      hcnt_q <= 8'h0; idx_q <= '0; sr_q <= 32'h0; rx_q <= 16'h0;
    end else if (go) begin
      busy_q   <= 1'b1;
      rd_err_q <= 1'b0;
      rd_q     <= go_rd;
      mdc_q    <= 1'b0;
      hcnt_q   <= half_m1;
      idx_q    <= f_pdis ? I_PRE : '0;
      sr_q     <= {f_st, f_op, f_port, f_dev, 2'b10, f_data};
      rx_q     <= 16'h0;
    end else if (busy_q) begin
      if (hcnt_q != 8'd0) begin
        hcnt_q <= hcnt_q - 8'd1;
      end else begin
        hcnt_q <= half_m1;
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (rd_q && in_frame) begin
            if (pos == IDX_W'(15)) rd_err_q <= mdio_i;
            else if (pos >= IDX_W'(16)) rx_q <= {rx_q[14:0], mdio_i};
          end
        end else begin
          mdc_q <= 1'b0;
          if (in_frame) sr_q <= {sr_q[30:0], 1'b0};
          if (idx_q == I_LAST) busy_q <= 1'b0;
          else idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic rd_err
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R3
  AST_MDC_MOVES_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> (busy || $past(busy))); // R3
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy); // R11
  AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R11
  AST_ERR_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rd_err); // R9
  AST_ERR_RISES_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> busy); // R8
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_err(rd_err_q)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam logic [3:0] A_STAT = 4'd12, A_CTRL = 4'd13, A_DATA = 4'd14, A_ADDR = 4'd15;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = A_STAT;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int nchk = 0, nerr = 0;
  int falls = 0, fall_base = 0, pre_n = 32;
  bit respond = 1'b0;
  logic [15:0] resp = 16'h0;
  logic phy_en = 1'b0, phy_bit = 1'b1;
  logic [63:0] cap = 64'h0, capoe = 64'h0;
  int busy_cyc, mdc_hi;

  always #2.5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_o};
    capoe = {capoe[62:0], mdio_oe};
  end

  always @(negedge mdc) begin
    int b;
    falls = falls + 1;
    b = falls - fall_base - pre_n;
    if (respond && b == 15) begin phy_en = 1'b1; phy_bit = 1'b0; end
    else if (respond && b >= 16 && b <= 31) begin phy_en = 1'b1; phy_bit = resp[31-b]; end
    else phy_en = 1'b0;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_STAT;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = A_STAT;
  endtask

  task automatic arm(input int pre, input bit r, input logic [15:0] rv);
    fall_base = falls; pre_n = pre; respond = r; resp = rv;
  endtask

  task automatic wait_done();
    busy_cyc = 0; mdc_hi = 0;
    bus_addr = A_STAT;
    for (int i = 0; i < 20000; i++) begin
      #1;
      if (!bus_rdata[0]) return;
      busy_cyc++;
      if (mdc) mdc_hi++;
      @(negedge clk);
    end
    nchk++; nerr++;
    $display("FAIL R9 busy never cleared actual=1 expected=0");
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_CTRL, v); check("R1 control", v, 0);
    rd(A_DATA, v); check("R1 data", v, 0);
    rd(A_ADDR, v); check("R1 address", v, 0);
    rd(4'd3, v);   check("R2 reserved word", v, 0);
    check("R1 mdc/oe", {mdc, mdio_oe}, 2'b00);
  endtask

  task automatic t_c22_write();
    logic [31:0] v;
    wr(A_STAT, 32'h0000_0200);
    wr(A_CTRL, 32'h0000_0071);
    rd(A_STAT, v); check("R2 status readback", v, 32'h0200);
    rd(A_CTRL, v); check("R2 control readback", v, 32'h0071);
    arm(32, 1'b0, 16'h0);
    wr(A_DATA, 32'h0000_BEEF);
    wait_done();
    check("R3 busy length div=2", busy_cyc, 64*2*2);
    check("R3 mdc high cycles", mdc_hi, 64*2);
    check("R4 R5 c22 write bits", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'h11, 2'b10, 16'hBEEF});
    check("R11 oe through write", capoe, {64{1'b1}});
    rd(A_DATA, v); check("R2 data readback", v, 32'hBEEF);
  endtask

  task automatic t_c22_read();
    logic [31:0] v;
    logic [63:0] exp;
    arm(32, 1'b1, 16'hA5C3);
    wr(A_CTRL, 32'h0000_8071);
    wait_done();
    check("R3 busy length read", busy_cyc, 256);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'h11, 18'h0};
    check("R5 c22 read header", cap[63:18], exp[63:18]);
    check("R7 release after 14 bits", capoe, {{46{1'b1}}, 18'h0});
    rd(A_DATA, v); check("R7 captured value", v, 32'hA5C3);
    rd(A_STAT, v); check("R8 no error when answered", v[1], 1'b0);
    rd(A_CTRL, v); check("R2 read bit not stored", v, 32'h0071);
  endtask

  task automatic t_read_noresp();
    logic [31:0] v;
    arm(32, 1'b0, 16'h0);
    wr(A_CTRL, 32'h0000_8071);
    wait_done();
    rd(A_STAT, v); check("R8 error flag set", v[1], 1'b1);
    rd(A_DATA, v); check("R8 floating line reads ones", v, 32'hFFFF);
    arm(32, 1'b0, 16'h0);
    wr(A_DATA, 32'h0000_1234);
    #1 check("R9 busy and error cleared at start", bus_rdata[1:0], 2'b01);
    bus_addr = A_DATA;
    #1 check("R9 data bit31 busy", bus_rdata[31], 1'b1);
    wait_done();
  endtask

  task automatic t_c45();
    logic [31:0] v;
    logic [63:0] exp;
    wr(A_STAT, 32'h0000_0040);
    wr(A_CTRL, 32'h0000_07E5);
    arm(0, 1'b0, 16'h0);
    wr(A_ADDR, 32'h0000_0123);
    wait_done();
    check("R3 min half period", busy_cyc, 64);
    check("R4 R6 c45 address frame", cap[31:0], {2'b00, 2'b00, 5'h1F, 5'h05, 2'b10, 16'h0123});
    rd(A_ADDR, v); check("R2 address readback", v, 32'h0123);
    arm(0, 1'b0, 16'h0);
    wr(A_DATA, 32'h0000_5A5A);
    wait_done();
    check("R6 c45 write frame", cap[31:0], {2'b00, 2'b01, 5'h1F, 5'h05, 2'b10, 16'h5A5A});
    arm(0, 1'b1, 16'h0F0F);
    wr(A_CTRL, 32'h0000_87E5);
    wait_done();
    exp = {32'h0, 2'b00, 2'b11, 5'h1F, 5'h05, 18'h0};
    check("R6 c45 read header", cap[31:18], exp[31:18]);
    check("R7 c45 release", capoe[31:0], {{14{1'b1}}, 18'h0});
    rd(A_DATA, v); check("R7 c45 captured value", v, 32'h0F0F);
  endtask

  task automatic t_c22_addr();
    logic [31:0] v;
    int seen = 0;
    wr(A_STAT, 32'h0000_0100);
    wr(A_ADDR, 32'h0000_00AB);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (bus_rdata[0] || mdc) seen++;
    end
    check("R6 no frame from address in c22", seen, 0);
    rd(A_ADDR, v); check("R6 address stored", v, 32'h00AB);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    arm(0, 1'b0, 16'h0);
    wr(A_DATA, 32'h0000_1111);
    wr(A_DATA, 32'h0000_2222);
    wr(A_CTRL, 32'h0000_8000);
    wr(A_STAT, 32'h0000_0540);
    wr(A_ADDR, 32'h0000_3333);
    wait_done();
    rd(A_DATA, v); check("R10 data unchanged", v, 32'h1111);
    rd(A_CTRL, v); check("R10 control unchanged", v, 32'h07E5);
    rd(A_STAT, v); check("R10 status unchanged", v, 32'h0100);
    rd(A_ADDR, v); check("R10 address unchanged", v, 32'h00AB);
    check("R10 sent frame kept first value", cap[31:0], {2'b01, 2'b01, 5'h1F, 5'h05, 2'b10, 16'h1111});
    repeat (4) @(negedge clk);
    #1 check("R10 no second frame", {bus_rdata[0], mdc}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_c22_write();
    t_c22_read();
    t_read_noresp();
    t_c45();
    t_c22_addr();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule